// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller with Wait Extension and Timeout Interrupt

This block sequences one access to an asynchronous external memory. Each access has three phases: setup, strobe and hold. Their lengths are programmed in clock cycles. When wait extension is switched on, the attached device can hold the strobe open by keeping its wait pin active. The block samples that pin through a two-flop synchronizer, and the pin only matters at the end of the programmed strobe and while the strobe is being stretched. A dedicated counter limits the stretch to (N+1)×16 cycles, where N is the programmed limit field. If the device still holds wait when the limit runs out, the block closes the strobe, finishes the access with its hold phase, and raises a timeout event in that same cycle.

The timeout event sets a status bit that software reads through a small register port. The status bit sets whether or not the interrupt is enabled. A masked view and an interrupt line are derived from the status bit and an enable bit. The enable is changed only by writing ones to a set address or a clear address. A write of one to the status address clears the status bit, and the interrupt line then drops.

Top module: `amw_strobe_ctrl`

## Requirements
- R1: An accepted access keeps `acc_busy` high for exactly S+T+H cycles, where S, T and H are the programmed setup and hold lengths and the actual strobe length. A programmed length of 0 counts as 1. `acc_done` is high for exactly one cycle, the last busy cycle.
- R2: With `cfg_ext_en` low, the wait pin is ignored. `strobe_o` stays high for exactly the programmed strobe length and no timeout status is set.
- R3: With `cfg_ext_en` high, if the synchronized wait is active in the last programmed strobe cycle, the strobe is extended. Once the pin goes inactive, the strobe ends in the second cycle after that change because of the two-flop synchronizer. Wait changes during setup are ignored.
- R4: The extension never exceeds L=(cfg_max_ext+1)×16 cycles. If wait is still active after L extension cycles, the strobe lasts exactly P+L cycles and the access completes.
- R5: A timeout sets status bit 0 at register address 0 on the edge that ends the strobe. The bit is visible in the first non-strobe cycle of that same access, whether or not the interrupt is enabled.
- R6: A read of address 1 returns status AND enable, with the timeout at bit 0.
- R7: Writing 1 in bit 0 at address 2 sets the enable. Writing 1 in bit 0 at address 3 clears it. Writing 0 has no effect. Both addresses read back the enable in bit 0.
- R8: `irq_o` equals status AND enable. Writing 1 in bit 0 at address 0 clears the status bit, and `irq_o` is low in the next cycle.
- R9: With `cfg_wait_pol` = 1 the wait pin is active high. With `cfg_wait_pol` = 0 it is active low.
- R10: `acc_req` is only accepted while idle. A request while busy neither restarts nor lengthens the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Start an access; accepted only when idle |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | High in the last hold cycle |
| strobe_o | output | 1 | Strobe phase, including any extension |
| wait_pin | input | 1 | Asynchronous wait input from the device |
| cfg_ext_en | input | 1 | Enables wait extension and timeout |
| cfg_wait_pol | input | 1 | 1: wait active high, 0: active low |
| cfg_max_ext | input | 4 | Extension limit field N, limit (N+1)×16 |
| cfg_setup | input | 4 | Setup length in cycles |
| cfg_strobe | input | 6 | Programmed strobe length in cycles |
| cfg_hold | input | 4 | Hold length in cycles |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 status, 1 masked, 2 enable set, 3 enable clear |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq_o | output | 1 | Timeout interrupt |

## Verification
On every cycle, the assertions check the following. A timeout never fires with extension disabled. Every timeout event is followed by a set status bit. Enable-set writes take effect, and the enable moves only on its own write-one commands. No strobe ever runs past the programmed length plus the limit. A finished access returns to idle. Busy only rises after a request. The clear-then-low behaviour of the interrupt is also checked on every cycle.

Only the bench scenarios can show the exact numbers. These are the strobe and busy lengths, the two-cycle release latency through the synchronizer, the timeout being seen on the very first access that runs over, polarity selection, and the read-back values at each address.

// File: rtl/amw_pkg.sv
package amw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_EXTWAIT,
        PH_HOLD
    } phase_e;

    localparam logic [1:0] RA_STATUS = 2'd0;
    localparam logic [1:0] RA_MASKED = 2'd1;
    localparam logic [1:0] RA_ENSET  = 2'd2;
    localparam logic [1:0] RA_ENCLR  = 2'd3;

    localparam int TMO_BIT = 0;

endpackage

// File: rtl/amw_wait_sync.sv
module amw_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/amw_phase_seq.sv
module amw_phase_seq
    import amw_pkg::*;
#(
    parameter int SETUP_W  = 4,
    parameter int STROBE_W = 6,
    parameter int HOLD_W   = 4,
    parameter int MAXW     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wait_act,
    input  logic                ext_en,
    input  logic [MAXW-1:0]     max_ext,
    input  logic [SETUP_W-1:0]  len_setup,
    input  logic [STROBE_W-1:0] len_strobe,
    input  logic [HOLD_W-1:0]   len_hold,
    output logic                busy,
    output logic                done,
    output logic                strobe,
    output logic                tmo_evt
);
    localparam int CW0 = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
    localparam int CW  = (CW0 > HOLD_W) ? CW0 : HOLD_W;
    localparam int EW  = MAXW + 4;

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [EW-1:0] ext;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [EW-1:0] ext_last;

    function automatic logic [CW-1:0] len_m1(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign ext_last = {max_ext, 4'hF};

    always_comb begin
        seq_d   = seq_q;
        tmo_evt = 1'b0;
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.ph  = PH_SETUP;
                    seq_d.cnt = len_m1(CW'(len_setup));
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph  = PH_STROBE;
                    seq_d.cnt = len_m1(CW'(len_strobe));
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end else if (ext_en && wait_act) begin
                    seq_d.ph  = PH_EXTWAIT;
                    seq_d.ext = '0;
                end else begin
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = len_m1(CW'(len_hold));
                end
            end
            PH_EXTWAIT: begin
                if (!ext_en || !wait_act) begin
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = len_m1(CW'(len_hold));
                end else if (seq_q.ext == ext_last) begin
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = len_m1(CW'(len_hold));
                    tmo_evt   = 1'b1;
                end else begin
                    seq_d.ext = seq_q.ext + 1'b1;
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt == '0) seq_d.ph = PH_IDLE;
                else                 seq_d.cnt = seq_q.cnt - 1'b1;
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, cnt: '0, ext: '0};
        else        seq_q <= seq_d;
    end

    assign busy   = (seq_q.ph != PH_IDLE);
    assign strobe = (seq_q.ph == PH_STROBE) || (seq_q.ph == PH_EXTWAIT);
    assign done   = (seq_q.ph == PH_HOLD) && (seq_q.cnt == '0);
endmodule

// File: rtl/amw_irq_regs.sv
module amw_irq_regs
    import amw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tmo_evt,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] raw_o,
    output logic [DW-1:0] en_o
);
    localparam logic [DW-1:0] VALID = DW'(1) << TMO_BIT;

    typedef struct packed {
        logic [DW-1:0] raw;
        logic [DW-1:0] en;
    } irq_t;

    irq_t irq_d, irq_q;
    logic [DW-1:0] wbits;
    logic [DW-1:0] evt_vec;

    assign wbits   = reg_wdata & VALID;
    assign evt_vec = tmo_evt ? VALID : '0;

    always_comb begin
        irq_d = irq_q;
        if (reg_wr) begin
            unique case (reg_addr)
                RA_STATUS: irq_d.raw = irq_q.raw & ~wbits;
                RA_ENSET:  irq_d.en  = irq_q.en | wbits;
                RA_ENCLR:  irq_d.en  = irq_q.en & ~wbits;
                default:   ;
            endcase
        end
        irq_d.raw = irq_d.raw | evt_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_STATUS: reg_rdata = irq_q.raw;
            RA_MASKED: reg_rdata = irq_q.raw & irq_q.en;
            default:   reg_rdata = irq_q.en;
        endcase
    end

    assign raw_o = irq_q.raw;
    assign en_o  = irq_q.en;
endmodule

// File: rtl/amw_strobe_ctrl.sv
module amw_strobe_ctrl
    import amw_pkg::*;
#(
    parameter int SETUP_W     = 4,
    parameter int STROBE_W    = 6,
    parameter int HOLD_W      = 4,
    parameter int MAXW        = 4,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_req,
    output logic                acc_busy,
    output logic                acc_done,
    output logic                strobe_o,
    input  logic                wait_pin,
    input  logic                cfg_ext_en,
    input  logic                cfg_wait_pol,
    input  logic [MAXW-1:0]     cfg_max_ext,
    input  logic [SETUP_W-1:0]  cfg_setup,
    input  logic [STROBE_W-1:0] cfg_strobe,
    input  logic [HOLD_W-1:0]   cfg_hold,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                irq_o
);
    logic          wait_sync;
    logic          wait_act;
    logic          tmo_evt;
    logic [DW-1:0] irq_raw;
    logic [DW-1:0] irq_en;

    amw_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (wait_pin),
        .dout (wait_sync)
    );

    // polarity 1: pin high means wait
    assign wait_act = wait_sync ~^ cfg_wait_pol;

    amw_phase_seq #(
        .SETUP_W (SETUP_W),
        .STROBE_W(STROBE_W),
        .HOLD_W  (HOLD_W),
        .MAXW    (MAXW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc_req),
        .wait_act  (wait_act),
        .ext_en    (cfg_ext_en),
        .max_ext   (cfg_max_ext),
        .len_setup (cfg_setup),
        .len_strobe(cfg_strobe),
        .len_hold  (cfg_hold),
        .busy      (acc_busy),
        .done      (acc_done),
        .strobe    (strobe_o),
        .tmo_evt   (tmo_evt)
    );

    amw_irq_regs #(.DW(DW)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmo_evt  (tmo_evt),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .raw_o    (irq_raw),
        .en_o     (irq_en)
    );

    assign irq_o = |(irq_raw & irq_en);
endmodule

// File: rtl/amw_strobe_ctrl_chk.sv
module amw_strobe_ctrl_chk
    import amw_pkg::*;
#(
    parameter int STROBE_W = 6,
    parameter int MAXW     = 4,
    parameter int DW       = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_req,
    input logic                acc_busy,
    input logic                acc_done,
    input logic                strobe_o,
    input logic                cfg_ext_en,
    input logic [MAXW-1:0]     cfg_max_ext,
    input logic [STROBE_W-1:0] cfg_strobe,
    input logic                reg_wr,
    input logic [1:0]          reg_addr,
    input logic [DW-1:0]       reg_wdata,
    input logic                tmo_evt,
    input logic [DW-1:0]       irq_raw,
    input logic [DW-1:0]       irq_en,
    input logic                irq_o
);
    logic [15:0] run_q;
    int          bound;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        run_q <= '0;
        else if (strobe_o) run_q <= run_q + 16'd1;
        else               run_q <= '0;
    end

    assign bound = ((cfg_strobe == '0) ? 1 : int'(cfg_strobe))
                 + (int'(cfg_max_ext) + 1) * 16;

    logic en_wr;
    assign en_wr = reg_wr && reg_addr[1] && reg_wdata[TMO_BIT];

    // R2
    no_tmo_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ext_en |-> !tmo_evt);

    // R5
    raw_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_evt |=> irq_raw[TMO_BIT]);

    // R7
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_ENSET && reg_wdata[TMO_BIT]) |=> irq_en[TMO_BIT]);

    // R7
    en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(irq_en));

    // R4
    strobe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (int'(run_q) < bound));

    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_busy);

    // R10
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_busy) |-> $past(acc_req));

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_STATUS && reg_wdata[TMO_BIT] && !tmo_evt) |=> !irq_o);
endmodule

bind amw_strobe_ctrl amw_strobe_ctrl_chk #(
    .STROBE_W(STROBE_W),
    .MAXW    (MAXW),
    .DW      (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .acc_busy   (acc_busy),
    .acc_done   (acc_done),
    .strobe_o   (strobe_o),
    .cfg_ext_en (cfg_ext_en),
    .cfg_max_ext(cfg_max_ext),
    .cfg_strobe (cfg_strobe),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tmo_evt    (tmo_evt),
    .irq_raw    (irq_raw),
    .irq_en     (irq_en),
    .irq_o      (irq_o)
);

// File: tb/test_amw_strobe_ctrl.sv
module test_amw_strobe_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_req = 1'b0;
    logic       acc_busy, acc_done, strobe_o;
    logic       wait_pin = 1'b0;
    logic       cfg_ext_en = 1'b0;
    logic       cfg_wait_pol = 1'b1;
    logic [3:0] cfg_max_ext = '0;
    logic [3:0] cfg_setup = 4'd1;
    logic [5:0] cfg_strobe = 6'd1;
    logic [3:0] cfg_hold = 4'd1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int checks = 0;
    int fails  = 0;
    bit en_model = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amw_strobe_ctrl i_amw_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_busy(acc_busy),
        .acc_done(acc_done), .strobe_o(strobe_o), .wait_pin(wait_pin),
        .cfg_ext_en(cfg_ext_en), .cfg_wait_pol(cfg_wait_pol),
        .cfg_max_ext(cfg_max_ext), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 2'd0;
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // expected strobe length and timeout flag from the requirements
    function automatic int exp_len(input int p, input bit ext, input bit act,
                                   input int n, input int rel, output bit tmo);
        int l = (n + 1) * 16;
        tmo = 1'b0;
        if (!ext || !act) return p;
        if (rel == 0 || rel + 2 > p + l) begin
            tmo = 1'b1;
            return p + l;
        end
        return (rel + 2 > p) ? rel + 2 : p;
    endfunction

    task automatic access(input int s, input int p, input int h, input bit ext,
                          input bit pol, input int n, input bit act, input int rel,
                          input bit poke);
        int  px = eff(p);
        int  elen;
        bit  etmo;
        int  busy_n = 0, st_n = 0, done_n = 0, guard = 0;
        bit  seen = 1'b0;
        bit  raw_at = 1'b0, irq_at = 1'b0;
        logic [7:0] v;
        elen = exp_len(px, ext, act, n, rel, etmo);
        wr(2'd0, 8'h01);
        @(negedge clk);
        cfg_setup = 4'(s); cfg_strobe = 6'(p); cfg_hold = 4'(h);
        cfg_ext_en = ext; cfg_wait_pol = pol; cfg_max_ext = 4'(n);
        wait_pin = act ? pol : ~pol;
        acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        while (acc_busy && guard < 2000) begin
            guard++;
            acc_req = 1'b0;
            busy_n++;
            if (acc_done) done_n++;
            if (strobe_o) begin
                st_n++;
                if (st_n == rel) wait_pin = ~pol;
            end else if (st_n > 0 && !seen) begin
                seen = 1'b1;
                raw_at = reg_rdata[0];
                irq_at = irq_o;
            end
            if (poke && busy_n == 2) acc_req = 1'b1;
            @(negedge clk);
        end
        acc_req = 1'b0;
        chk(busy_n == eff(s) + elen + eff(h), "R1 busy length", busy_n, eff(s) + elen + eff(h));
        chk(done_n == 1, "R1 done pulse count", done_n, 1);
        if (!ext) chk(st_n == px, "R2 strobe length, extension off", st_n, px);
        else if (etmo) chk(st_n == elen, "R4 strobe length at timeout", st_n, elen);
        else chk(st_n == elen, "R3 strobe length with wait", st_n, elen);
        chk(raw_at == etmo, "R5 status on timing-out access", raw_at, etmo);
        chk(irq_at == (etmo & en_model), "R8 irq at strobe end", irq_at, etmo & en_model);
        rd(2'd1, v);
        chk(v[0] == (etmo & en_model), "R6 masked read", v[0], etmo & en_model);
        if (poke) begin
            @(negedge clk);
            chk(!acc_busy, "R10 request while busy ignored", acc_busy, 0);
        end
        wr(2'd0, 8'h01);
        rd(2'd0, v);
        chk(v[0] == 1'b0 && !irq_o, "R8 status cleared, irq low", {v[0], irq_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd7071));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!acc_busy && !strobe_o && !irq_o, "R1 reset outputs idle", {acc_busy, strobe_o, irq_o}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 8'h00, "R7 reset register value", v, 0);
        end

        // enable set/clear semantics
        wr(2'd2, 8'h00); rd(2'd2, v);
        chk(v[0] == 1'b0, "R7 set-write of 0 no effect", v[0], 0);
        wr(2'd2, 8'h01); rd(2'd2, v);
        chk(v[0] == 1'b1, "R7 set-write of 1", v[0], 1);
        wr(2'd3, 8'h00); rd(2'd3, v);
        chk(v[0] == 1'b1, "R7 clear-write of 0 no effect", v[0], 1);
        wr(2'd3, 8'h01); rd(2'd3, v);
        chk(v[0] == 1'b0, "R7 clear-write of 1", v[0], 0);
        en_model = 1'b0;

        // directed: plain access, zero lengths, extension off with wait held
        access(0, 0, 0, 1'b0, 1'b1, 0, 1'b0, 0, 1'b0);
        access(2, 5, 3, 1'b0, 1'b1, 0, 1'b1, 0, 1'b0);
        // timeout with enable off: status only
        access(1, 3, 1, 1'b1, 1'b1, 0, 1'b1, 0, 1'b0);
        // timeout with enable on, on first access, active-low wait (R9)
        wr(2'd2, 8'h01); en_model = 1'b1;
        access(2, 4, 2, 1'b1, 1'b0, 1, 1'b1, 0, 1'b0);
        // release during extension, at boundary, and before strobe end
        access(1, 4, 1, 1'b1, 1'b1, 0, 1'b1, 10, 1'b0);
        access(1, 4, 1, 1'b1, 1'b1, 0, 1'b1, 18, 1'b0);
        access(1, 4, 1, 1'b1, 1'b1, 0, 1'b1, 19, 1'b0);
        access(1, 6, 1, 1'b1, 1'b0, 0, 1'b1, 1, 1'b0);
        // wait inactive, polarity low (R9)
        access(3, 2, 2, 1'b1, 1'b0, 0, 1'b0, 0, 1'b0);
        // request while busy
        access(2, 3, 2, 1'b0, 1'b1, 0, 1'b0, 0, 1'b1);

        // constrained random
        for (int i = 0; i < 30; i++) begin
            int  s = $urandom_range(0, 15);
            int  p = $urandom_range(0, 63);
            int  h = $urandom_range(0, 15);
            int  n = $urandom_range(0, 2);
            bit  ext = 1'($urandom_range(0, 1));
            bit  pol = 1'($urandom_range(0, 1));
            bit  act = 1'($urandom_range(0, 1));
            int  rel = $urandom_range(0, eff(p) + (n + 1) * 16 + 4);
            if ($urandom_range(0, 3) == 0) begin
                if (en_model) wr(2'd3, 8'h01); else wr(2'd2, 8'h01);
                en_model = ~en_model;
            end
            access(s, p, h, ext, pol, n, act, rel, 1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule